// File: doc/BRIEF.md
# Configurable Output Macrocell Array

This block is the output stage of a small programmable sum-of-products device. Eight identical macrocells each take the product terms that the AND array computes for them. Each cell turns those terms into a pin drive value, a tri-state enable and one feedback column that goes back into the array. Two global bits choose one of three device-wide modes: clocked, full-enable and plain. Two bits per cell choose the cell's own behaviour: a configuration bit and a polarity bit. The mode decides where each cell gets its output enable and how many product terms feed its logic sum. It also decides what each feedback column carries.

A single clock input clocks all registers. A synchronous active-high reset clears all registers, which models the power-on clear. A preload port forces each register to a chosen value, so that unreachable states can be set up for test. Cells are numbered 0 to NCELL-1. Cells 0 and NCELL-1 are the outer cells, next to the dedicated clock-side and enable-side inputs. Cells NCELL/2-1 and NCELL/2 are the centre pair.

Top module: `olmc_array`

## Requirements
- R1: Mode decode from `syn`/`ac0` is: 0/1 clocked, 1/1 full-enable, 1/0 plain. The combination 0/0 is illegal. In the illegal mode every `pin_oe` and every `fb` bit is 0 and no register loads from the array.
- R2: In clocked mode, a cell with `ac1`=0 is registered. At each clock edge its register stores the OR of all NPT terms with the polarity applied. `pin_drv` follows one cycle later. The output enable is the inverse of `pin11_in`, so the enable input is active low.
- R3: In clocked mode, a cell with `ac1`=1 is combinational. Term 0 (`pterm[i*NPT]`) is its output enable, and terms 1 to NPT-1 form its logic sum.
- R4: In full-enable mode, every cell uses term 0 as its enable and terms 1 to NPT-1 as its logic sum, whatever its `ac1` value.
- R5: In plain mode, a cell with `ac1`=0 is always enabled and uses all NPT terms. A cell with `ac1`=1 is a dedicated input with its output disabled. The centre pair is always an enabled output, whatever its `ac1` value.
- R6: Polarity: with `xpol`=1 the pin shows the logic sum, and with `xpol`=0 it shows the sum's inverse. This holds in every mode, including the registered path.
- R7: Reset clears every register to 0. While reset is active and afterwards, until the next load, a registered cell drives 1 and feeds back 1.
- R8: When `preload_en` is high at a clock edge, and reset is not, every register takes `preload_data[i]`, overriding its array input. A registered cell then drives and feeds back the inverse of that bit.
- R9: In clocked mode, the feedback of a registered cell is its inverted register output. The feedback of a combinational cell is its pad level: `pin_drv` when enabled, `pin_in` otherwise.
- R10: In full-enable mode, column 0 carries `pin1_in` and column NCELL-1 carries `pin11_in`. Every other column carries its own cell's pad level.
- R11: In plain mode, columns 0 and NCELL-1 are fed as in R10. Columns 1 to NCELL/2-1 carry the pad of cell i-1, and columns NCELL/2 to NCELL-2 carry the pad of cell i+1. The centre pair's pads reach no column.
- R12: A register whose cell is not a registered cell holds its value across clock edges. Only reset and preload change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared register clock |
| rst | input | 1 | Synchronous active-high power-on clear |
| syn | input | 1 | Global mode bit, selects clocked when 0 |
| ac0 | input | 1 | Global mode bit |
| ac1 | input | NCELL | Per-cell configuration bit |
| xpol | input | NCELL | Per-cell polarity, 1 = active high |
| pterm | input | NCELL*NPT | Product terms, cell i at bits i*NPT upward |
| pin_in | input | NCELL | External level on each cell's pin |
| pin1_in | input | 1 | Level of the clock-side dedicated input |
| pin11_in | input | 1 | Level of the enable-side input, active-low enable in clocked mode |
| preload_en | input | 1 | Force registers at the next edge |
| preload_data | input | NCELL | Preload values, one per register |
| pin_drv | output | NCELL | Value driven toward each pin |
| pin_oe | output | NCELL | Tri-state enable for each pin |
| fb | output | NCELL | Feedback column per cell into the array |

## Verification
The bench builds the array with its defaults, NCELL=8 and NPT=8. With these values both outer cells, the centre pair and the cells between them are present together. So the routing of every feedback column, including the neighbour swap in plain mode and the dedicated inputs on the outer columns, can be compared against a model. Eight terms per cell make term 0 distinguishable from the other seven, so taking term 0 away as an enable is visible at the pins. The bench steps through all four `syn`/`ac0` codes with random terms, polarities and configuration bits. It adds a reset in the middle of the run and a preload that lands while a cell is not registered.

// File: rtl/olmc_pkg.sv
package olmc_pkg;

    typedef enum logic [1:0] {
        MODE_BAD = 2'd0,
        MODE_REG = 2'd1,
        MODE_CPX = 2'd2,
        MODE_SMP = 2'd3
    } mode_e;

    typedef struct packed {
        logic q;
    } cell_state_t;

    function automatic mode_e decode_mode(input logic syn, input logic ac0);
        mode_e m;
        case ({syn, ac0})
            2'b01:   m = MODE_REG;
            2'b11:   m = MODE_CPX;
            2'b10:   m = MODE_SMP;
            default: m = MODE_BAD;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/olmc_mode_dec.sv
module olmc_mode_dec
    import olmc_pkg::*;
(
    input  logic  syn,
    input  logic  ac0,
    output mode_e mode
);

    always_comb begin
        mode = decode_mode(syn, ac0);
    end

endmodule

// File: rtl/olmc_cell.sv
module olmc_cell
    import olmc_pkg::*;
#(
    parameter int NPT    = 8,
    parameter bit CENTRE = 1'b0
) (
    input  logic           clk,
    input  logic           rst,
    input  mode_e          mode,
    input  logic           ac1,
    input  logic           xpol,
    input  logic [NPT-1:0] pt,
    input  logic           oe_pin_n,
    input  logic           preload_en,
    input  logic           preload_bit,
    output logic           drv,
    output logic           oe,
    output logic           q
);

    cell_state_t st_d, st_q;
    logic sum_all, sum_tail, reg_cell, d_val;

    always_comb begin
        sum_all  = |pt;
        sum_tail = |pt[NPT-1:1];
        reg_cell = (mode == MODE_REG) && !ac1;
        // register holds the inverse of the pin value it will present
        d_val    = xpol ? ~sum_all : sum_all;

        drv = 1'b0;
        oe  = 1'b0;
        unique case (mode)
            MODE_REG: begin
                if (!ac1) begin
                    drv = ~st_q.q;
                    oe  = ~oe_pin_n;
                end else begin
                    drv = xpol ? sum_tail : ~sum_tail;
                    oe  = pt[0];
                end
            end
            MODE_CPX: begin
                drv = xpol ? sum_tail : ~sum_tail;
                oe  = pt[0];
            end
            MODE_SMP: begin
                drv = xpol ? sum_all : ~sum_all;
                oe  = CENTRE ? 1'b1 : ~ac1;
            end
            default: begin
                drv = 1'b0;
                oe  = 1'b0;
            end
        endcase

        st_d = st_q;
        if (rst) begin
            st_d.q = 1'b0;
        end else if (preload_en) begin
            st_d.q = preload_bit;
        end else if (reg_cell) begin
            st_d.q = d_val;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q = st_q.q;

endmodule

// File: rtl/olmc_fb_route.sv
module olmc_fb_route
    import olmc_pkg::*;
#(
    parameter int NCELL = 8
) (
    input  mode_e            mode,
    input  logic [NCELL-1:0] ac1,
    input  logic [NCELL-1:0] q,
    input  logic [NCELL-1:0] pad,
    input  logic             pin1_in,
    input  logic             pin11_in,
    output logic [NCELL-1:0] fb
);

    localparam int HALF = NCELL / 2;

    for (genvar i = 0; i < NCELL; i++) begin : g_col
        logic cpx_src, smp_src;

        if (i == 0) begin : g_first
            assign cpx_src = pin1_in;
            assign smp_src = pin1_in;
        end else if (i == NCELL - 1) begin : g_last
            assign cpx_src = pin11_in;
            assign smp_src = pin11_in;
        end else if (i < HALF) begin : g_lo
            assign cpx_src = pad[i];
            assign smp_src = pad[i-1];
        end else begin : g_hi
            assign cpx_src = pad[i];
            assign smp_src = pad[i+1];
        end

        always_comb begin
            unique case (mode)
                MODE_REG: fb[i] = ac1[i] ? pad[i] : ~q[i];
                MODE_CPX: fb[i] = cpx_src;
                MODE_SMP: fb[i] = smp_src;
                default:  fb[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/olmc_array.sv
module olmc_array
    import olmc_pkg::*;
#(
    parameter int NCELL = 8,
    parameter int NPT   = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   syn,
    input  logic                   ac0,
    input  logic [NCELL-1:0]       ac1,
    input  logic [NCELL-1:0]       xpol,
    input  logic [NCELL*NPT-1:0]   pterm,
    input  logic [NCELL-1:0]       pin_in,
    input  logic                   pin1_in,
    input  logic                   pin11_in,
    input  logic                   preload_en,
    input  logic [NCELL-1:0]       preload_data,
    output logic [NCELL-1:0]       pin_drv,
    output logic [NCELL-1:0]       pin_oe,
    output logic [NCELL-1:0]       fb
);

    localparam int HALF = NCELL / 2;

    mode_e            mode;
    logic [NCELL-1:0] q;
    logic [NCELL-1:0] pad;

    olmc_mode_dec u_dec (
        .syn  (syn),
        .ac0  (ac0),
        .mode (mode)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        localparam bit IS_CTR = (i == HALF - 1) || (i == HALF);

        olmc_cell #(
            .NPT    (NPT),
            .CENTRE (IS_CTR)
        ) u_cell (
            .clk         (clk),
            .rst         (rst),
            .mode        (mode),
            .ac1         (ac1[i]),
            .xpol        (xpol[i]),
            .pt          (pterm[i*NPT +: NPT]),
            .oe_pin_n    (pin11_in),
            .preload_en  (preload_en),
            .preload_bit (preload_data[i]),
            .drv         (pin_drv[i]),
            .oe          (pin_oe[i]),
            .q           (q[i])
        );
    end

    // level seen on each pad: own drive when enabled, external otherwise
    assign pad = (pin_oe & pin_drv) | (~pin_oe & pin_in);

    olmc_fb_route #(
        .NCELL (NCELL)
    ) u_route (
        .mode     (mode),
        .ac1      (ac1),
        .q        (q),
        .pad      (pad),
        .pin1_in  (pin1_in),
        .pin11_in (pin11_in),
        .fb       (fb)
    );

endmodule

// File: rtl/olmc_array_chk.sv
module olmc_array_chk #(
    parameter int NCELL = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             syn,
    input logic             ac0,
    input logic [NCELL-1:0] ac1,
    input logic             pin1_in,
    input logic             pin11_in,
    input logic             preload_en,
    input logic [NCELL-1:0] preload_data,
    input logic [NCELL-1:0] pin_drv,
    input logic [NCELL-1:0] pin_oe,
    input logic [NCELL-1:0] fb
);

    localparam int HALF = NCELL / 2;

    p_illegal_off_r1: assert property (@(posedge clk) disable iff (rst)
        (!syn && !ac0) |-> (pin_oe == '0 && fb == '0));

    p_centre_on_r5: assert property (@(posedge clk) disable iff (rst)
        (syn && !ac0) |-> (pin_oe[HALF-1] && pin_oe[HALF]));

    p_outer_cols_r10: assert property (@(posedge clk) disable iff (rst)
        (syn && ac0) |-> (fb[0] == pin1_in && fb[NCELL-1] == pin11_in));

    for (genvar i = 0; i < NCELL; i++) begin : g_chk
        p_reset_high_r7: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) && !syn && ac0 && !ac1[i] && !pin11_in)
            |-> (pin_drv[i] && pin_oe[i]));

        p_preload_r8: assert property (@(posedge clk) disable iff (rst)
            ($past(preload_en) && !$past(rst) && !syn && ac0 && !ac1[i])
            |-> (pin_drv[i] == !$past(preload_data[i])));

        p_reg_fb_r9: assert property (@(posedge clk) disable iff (rst)
            (!syn && ac0 && !ac1[i]) |-> (fb[i] == pin_drv[i]));
    end

endmodule

bind olmc_array olmc_array_chk #(.NCELL(NCELL)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .syn          (syn),
    .ac0          (ac0),
    .ac1          (ac1),
    .pin1_in      (pin1_in),
    .pin11_in     (pin11_in),
    .preload_en   (preload_en),
    .preload_data (preload_data),
    .pin_drv      (pin_drv),
    .pin_oe       (pin_oe),
    .fb           (fb)
);

// File: tb/olmc_array_tb.sv
module olmc_array_tb;

    localparam int NC = 8;
    localparam int NP = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst, syn, ac0, pin1_in, pin11_in, preload_en;
    logic [NC-1:0]    ac1, xpol, pin_in, preload_data;
    logic [NC*NP-1:0] pterm;
    logic [NC-1:0]    pin_drv, pin_oe, fb;
    logic [NC-1:0]    mq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    olmc_array #(.NCELL(NC), .NPT(NP)) u_dut (
        .clk(clk), .rst(rst), .syn(syn), .ac0(ac0), .ac1(ac1), .xpol(xpol),
        .pterm(pterm), .pin_in(pin_in), .pin1_in(pin1_in), .pin11_in(pin11_in),
        .preload_en(preload_en), .preload_data(preload_data),
        .pin_drv(pin_drv), .pin_oe(pin_oe), .fb(fb)
    );

    // 0 illegal, 1 clocked, 2 full-enable, 3 plain
    function automatic int cur_mode();
        if (!syn) return ac0 ? 1 : 0;
        return ac0 ? 2 : 3;
    endfunction

    task automatic expect_out(output logic [NC-1:0] ed, output logic [NC-1:0] eo,
                              output logic [NC-1:0] ef);
        logic [NC-1:0] pad;
        int m;
        m = cur_mode();
        for (int i = 0; i < NC; i++) begin
            logic sa, st;
            sa = |pterm[i*NP +: NP];
            st = |pterm[i*NP+1 +: NP-1];
            ed[i] = 1'b0;
            eo[i] = 1'b0;
            if (m == 1) begin
                if (!ac1[i]) begin ed[i] = ~mq[i]; eo[i] = ~pin11_in; end
                else begin ed[i] = xpol[i] ? st : ~st; eo[i] = pterm[i*NP]; end
            end else if (m == 2) begin
                ed[i] = xpol[i] ? st : ~st;
                eo[i] = pterm[i*NP];
            end else if (m == 3) begin
                ed[i] = xpol[i] ? sa : ~sa;
                eo[i] = (i == NC/2-1 || i == NC/2) ? 1'b1 : ~ac1[i];
            end
            pad[i] = eo[i] ? ed[i] : pin_in[i];
        end
        for (int i = 0; i < NC; i++) begin
            ef[i] = 1'b0;
            if (m == 1) ef[i] = ac1[i] ? pad[i] : ~mq[i];
            else if (m >= 2) begin
                if (i == 0) ef[i] = pin1_in;
                else if (i == NC-1) ef[i] = pin11_in;
                else if (m == 2) ef[i] = pad[i];
                else if (i < NC/2) ef[i] = pad[i-1];
                else ef[i] = pad[i+1];
            end
        end
    endtask

    task automatic update_model();
        for (int i = 0; i < NC; i++) begin
            logic sa;
            sa = |pterm[i*NP +: NP];
            if (rst) mq[i] = 1'b0;
            else if (preload_en) mq[i] = preload_data[i];
            else if (!syn && ac0 && !ac1[i]) mq[i] = xpol[i] ? ~sa : sa;
        end
    endtask

    task automatic check1(string lbl, string what, logic [NC-1:0] got, logic [NC-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b expected %b", lbl, what, got, exp);
        end
    endtask

    task automatic cyc(string lbl);
        logic [NC-1:0] ed, eo, ef;
        #1;
        expect_out(ed, eo, ef);
        check1(lbl, "pin_drv", pin_drv, ed);
        check1(lbl, "pin_oe", pin_oe, eo);
        check1(lbl, "fb", fb, ef);
        @(posedge clk);
        update_model();
        @(negedge clk);
    endtask

    task automatic rand_inputs(bit allow_pl);
        pterm        = {$urandom, $urandom};
        pin_in       = NC'($urandom);
        xpol         = NC'($urandom);
        ac1          = NC'($urandom);
        pin1_in      = 1'($urandom);
        pin11_in     = 1'($urandom);
        preload_data = NC'($urandom);
        preload_en   = allow_pl ? (($urandom % 16) == 0) : 1'b0;
    endtask

    task automatic run_rand(int n, bit s, bit a, bit pl, string lbl);
        for (int k = 0; k < n; k++) begin
            rand_inputs(pl);
            syn = s;
            ac0 = a;
            cyc(lbl);
        end
    endtask

    initial begin
        rst = 1'b1; syn = 1'b0; ac0 = 1'b1; ac1 = '0; xpol = 8'h5A;
        pterm = '1; pin_in = '0; pin1_in = 1'b0; pin11_in = 1'b0;
        preload_en = 1'b0; preload_data = '0; mq = '0;
        repeat (2) @(posedge clk);
        mq = '0;
        @(negedge clk);
        // R7: cleared registers drive 1 whatever the polarity
        cyc("R7");
        xpol = 8'h0F;
        cyc("R7");
        rst = 1'b0;
        pterm = '0;
        cyc("R7");
        // R1: illegal mode code
        run_rand(12, 1'b0, 1'b0, 1'b1, "R1");
        // R2 registered cells, R6 polarity, R9 feedback
        for (int k = 0; k < 60; k++) begin
            rand_inputs(1'b0);
            syn = 1'b0; ac0 = 1'b1; ac1 = '0; pin11_in = 1'b0;
            cyc("R2 R6 R9");
        end
        // R3 combinational cells in clocked mode
        for (int k = 0; k < 60; k++) begin
            rand_inputs(1'b0);
            syn = 1'b0; ac0 = 1'b1; ac1 = '1;
            cyc("R3 R6 R9");
        end
        run_rand(200, 1'b0, 1'b1, 1'b1, "R2 R3 R8 R9");
        run_rand(150, 1'b1, 1'b1, 1'b1, "R4 R6 R10");
        run_rand(150, 1'b1, 1'b0, 1'b1, "R5 R6 R11");
        // R8: preload overrides the array input
        syn = 1'b0; ac0 = 1'b1; ac1 = '0; pterm = '1; pin11_in = 1'b0;
        preload_en = 1'b1; preload_data = 8'h3C;
        cyc("R8");
        preload_en = 1'b0;
        cyc("R8");
        // R12: preload in plain mode, then hold over many edges
        syn = 1'b1; ac0 = 1'b0; preload_en = 1'b1; preload_data = 8'hA5;
        cyc("R12");
        run_rand(20, 1'b1, 1'b0, 1'b0, "R12");
        run_rand(10, 1'b1, 1'b1, 1'b0, "R12");
        syn = 1'b0; ac0 = 1'b1; ac1 = '0; pin11_in = 1'b0; preload_en = 1'b0;
        cyc("R12");
        // R7: reset again mid-run
        rst = 1'b1;
        run_rand(3, 1'b1, 1'b1, 1'b1, "R7");
        rst = 1'b0;
        syn = 1'b0; ac0 = 1'b1; ac1 = '0; pin11_in = 1'b0; preload_en = 1'b0;
        cyc("R7");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) got hang expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule